// File: doc/BRIEF.md
# Cascaded BCD Up Counter with Snapshot Latch

This block counts events in decimal. Two low decades of prescaling happen outside the block. The block receives both prescaler digits. The upper two bits of the second prescaler digit are ORed together to form a count clock. Every falling edge of that clock advances an internal chain of BCD decades by one. A sticky overflow flag records the first falling edge of its source. That source is either an external pin or, when a parameter selects it, the top bit of one of the upper decades.

An active-low load strobe copies a complete snapshot into a holding latch. The snapshot holds both prescaler digits, every internal decade and the overflow flag. Between loads the latch keeps its outputs steady, so the counter keeps running while a display or host reads a stable value.

Every asynchronous input passes through a two-flop synchronizer on the single system clock. Falling edges are found by comparing each synchronized value with the value one cycle earlier.

Top module: `bcd_snap_counter`

## Requirements
- R1: The count clock is `pre_hi_i[2] | pre_hi_i[3]`, the weights 4 and 8 of the second prescaler digit. A falling edge of this OR advances the counter whether both bits toggle or only one of them does while the other stays low.
- R2: The counter holds NUM_DEC BCD digits, each in 0..9. It rises by exactly one decimal step for each count-clock falling edge, with decimal carry. Without a falling edge it holds its value.
- R3: Incrementing from all nines gives all zeros.
- R4: While `clr_ni` is low, the counter is forced to zero and the overflow flip-flop is cleared, and an overflow edge during that time has no effect. The latched outputs are not changed by `clr_ni`.
- R5: The overflow flip-flop sets on a falling edge of its source and stays set until `clr_ni` is low. Rising edges and further falling edges of the source change nothing.
- R6: Parameter OVF_SRC chooses the overflow source. The value 0 selects the `ovf_i` pin. A value k in 3..NUM_DEC+2 selects bit 3 of overall decade k, so the flag sets when that decade goes from 9 to 0.
- R7: While `load_ni` is low, the latch takes new data on every cycle. The layout is `digits_o[3:0]` = `pre_lo_i`, `digits_o[7:4]` = `pre_hi_i`, and `digits_o[4*k+3:4*k]` = internal decade k-1 for k ≥ 2, least significant first. While `load_ni` is high, `digits_o` holds its value.
- R8: `ovf_o` takes the overflow flip-flop state on the same load that updates `digits_o`, and holds it while `load_ni` is high.
- R9: `rst_ni` clears the counter, the overflow flip-flop and both latched outputs asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Counter and overflow clear, active low |
| load_ni | input | 1 | Snapshot strobe, active low |
| pre_lo_i | input | 4 | First external prescaler BCD digit |
| pre_hi_i | input | 4 | Second external prescaler BCD digit; bits 2 and 3 form the count clock |
| ovf_i | input | 1 | External overflow source, falling-edge active |
| digits_o | output | (NUM_DEC+2)*4 | Latched BCD digits, least significant first |
| ovf_o | output | 1 | Latched overflow flag |

## Verification
The hardest cases to reach are the wrap from all nines and the internally sourced overflow. Both require the count to pass through every value of the top decade. The bench therefore runs a second instance with three internal decades and its overflow source tied to the top decade's MSB. It then clocks about a thousand count edges, taking snapshots at 099, 100, 999 and 000. A clear is also held low while an overflow edge arrives, so the bench can show that clear wins. Between loads the outputs are checked while the counter moves, which confirms that the latch is frozen.

// File: rtl/bcd_snap_pkg.sv
package bcd_snap_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int         WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fall_det.sv
module fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign fall_o = prev_q & ~d_i;
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain import bcd_snap_pkg::*; #(
  parameter int NUM_DEC = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     inc_i,
  output logic [NUM_DEC*BCD_W-1:0] digits_o
);
  logic [NUM_DEC:0] carry;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    bcd_t dig_q;
    assign carry[i+1] = carry[i] & (dig_q == BCD_MAX);
    assign digits_o[i*BCD_W +: BCD_W] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;
      else if (carry[i]) dig_q <= (dig_q == BCD_MAX) ? '0 : dig_q + 1'b1;
    end

    AST_BCD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dig_q <= BCD_MAX); // R2
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> digits_o == '0); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && carry[NUM_DEC]) |=> digits_o == '0); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(digits_o)); // R2
endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R7
  AST_LATCH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i)); // R7
endmodule

// File: rtl/bcd_snap_counter.sv
module bcd_snap_counter import bcd_snap_pkg::*; #(
  parameter int NUM_DEC = 6,
  parameter int OVF_SRC = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_ni,
  input  logic                         load_ni,
  input  logic [3:0]                   pre_lo_i,
  input  logic [3:0]                   pre_hi_i,
  input  logic                         ovf_i,
  output logic [(NUM_DEC+2)*BCD_W-1:0] digits_o,
  output logic                         ovf_o
);
  localparam int CNT_W   = NUM_DEC * BCD_W;
  localparam int DW      = CNT_W + 2 * BCD_W;
  localparam int SYNC_W  = 3 + 2 * BCD_W;
  localparam int OVF_IDX = (OVF_SRC >= 3) ? OVF_SRC - 3 : NUM_DEC - 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(3); // clr/load idle high

  logic [SYNC_W-1:0] sync_q;
  logic              clr_s, load_s, ovf_s;
  bcd_t              pre_lo_s, pre_hi_s;
  logic              cnt_clk, cnt_fall;
  logic              ovf_src, ovf_fall, ovf_q;
  logic [CNT_W-1:0]  cnt_digits;

  sync2 #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pre_hi_i, pre_lo_i, ovf_i, load_ni, clr_ni}),
    .q_o   (sync_q)
  );

  assign {pre_hi_s, pre_lo_s, ovf_s, load_s, clr_s} = sync_q;

  // count clock: weights 4 and 8 of second prescaler digit
  assign cnt_clk = pre_hi_s[2] | pre_hi_s[3];

  fall_det u_cnt_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_clk),
    .fall_o(cnt_fall)
  );

  bcd_chain #(.NUM_DEC(NUM_DEC)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!clr_s),
    .inc_i   (cnt_fall),
    .digits_o(cnt_digits)
  );

  assign ovf_src = (OVF_SRC == 0) ? ovf_s : cnt_digits[OVF_IDX*BCD_W + 3];

  fall_det u_ovf_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ovf_src),
    .fall_o(ovf_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= 1'b0;
    else if (!clr_s)   ovf_q <= 1'b0;
    else if (ovf_fall) ovf_q <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && clr_s) |=> ovf_q); // R5
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_fall && clr_s) |=> ovf_q); // R5
  AST_OVF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> !ovf_q); // R4

  snap_latch #(.WIDTH(DW + 1)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(!load_s),
    .d_i   ({ovf_q, cnt_digits, pre_hi_s, pre_lo_s}),
    .q_o   ({ovf_o, digits_o})
  );

  AST_OVF_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_s |=> $stable(ovf_o)); // R8
endmodule

// File: tb/bcd_snap_counter_test.sv
module bcd_snap_counter_test;
  localparam int ND = 3;
  localparam int DW = (ND + 2) * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, ovf_in = 1'b0;
  logic [3:0] pre_lo = '0, pre_hi = '0;
  logic [DW-1:0] dig, dig_int;
  logic ovf_out, ovf_int;

  always #10 clk = ~clk;

  bcd_snap_counter #(.NUM_DEC(ND), .OVF_SRC(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .pre_lo_i(pre_lo), .pre_hi_i(pre_hi), .ovf_i(ovf_in),
    .digits_o(dig), .ovf_o(ovf_out));

  bcd_snap_counter #(.NUM_DEC(ND), .OVF_SRC(5)) uut_int (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .pre_lo_i(pre_lo), .pre_hi_i(pre_hi), .ovf_i(1'b0),
    .digits_o(dig_int), .ovf_o(ovf_int));

  typedef struct {
    logic [DW-1:0] digits;
    logic          ovf;
    logic          ovf_i2;
    string         tag;
  } exp_t;

  exp_t q[$];
  event mon_ev;
  int checks = 0, errors = 0;
  int cnt_m = 0;
  logic ovf_m = 1'b0, ovf_int_m = 1'b0;
  exp_t last_snap;

  function automatic logic [DW-1:0] model_digits();
    logic [DW-1:0] r;
    r = {4'(cnt_m / 100), 4'((cnt_m / 10) % 10), 4'(cnt_m % 10), pre_hi, pre_lo};
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations and compares outputs
  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check1({e.tag, " digits"}, dig, e.digits);
        check1({e.tag, " digits_int"}, dig_int, e.digits);
        check1({e.tag, " ovf"}, DW'(ovf_out), DW'(e.ovf));
        check1({e.tag, " ovf_int"}, DW'(ovf_int), DW'(e.ovf_i2));
      end
    end
  end

  task automatic pulse(input logic [3:0] hi_val);
    pre_hi = hi_val; cyc(3);
    pre_hi = 4'd0;   cyc(3);
    cnt_m = (cnt_m + 1) % 1000;
    if (cnt_m == 0) ovf_int_m = 1'b1;
  endtask

  task automatic snapshot(input string tag);
    exp_t e;
    e.digits = model_digits(); e.ovf = ovf_m; e.ovf_i2 = ovf_int_m; e.tag = tag;
    q.push_back(e);
    last_snap = e;
    load_n = 1'b0; cyc(4);
    load_n = 1'b1; cyc(4);
    ->mon_ev;
    cyc(1);
  endtask

  task automatic expect_held(input string tag);
    exp_t e;
    e = last_snap; e.tag = tag;
    q.push_back(e);
    ->mon_ev;
    cyc(1);
  endtask

  task automatic clear(input bit ovf_during);
    clr_n = 1'b0; cyc(3);
    if (ovf_during) begin
      ovf_in = 1'b1; cyc(3); ovf_in = 1'b0; cyc(5);
    end else cyc(2);
    clr_n = 1'b1; cyc(4);
    cnt_m = 0; ovf_m = 1'b0; ovf_int_m = 1'b0;
  endtask

  task automatic ovf_pulse();
    ovf_in = 1'b1; cyc(3);
    ovf_in = 1'b0; cyc(4);
    ovf_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    // R9: reset state of latched outputs
    check1("R9 reset digits", dig, '0);
    check1("R9 reset ovf", DW'(ovf_out), '0);
    rst_n = 1'b1; cyc(3);

    pre_lo = 4'd5; pre_hi = 4'd2; cyc(1);
    snapshot("R7 prescaler digits");

    pre_lo = 4'd0; pre_hi = 4'd0; cyc(1);
    for (int i = 0; i < 7; i++) pulse(4'b0100);
    snapshot("R1 bit4 alone R2");
    for (int i = 0; i < 5; i++) pulse(4'b1000);
    snapshot("R1 bit8 alone");

    // R1: full prescaler cycles 0..9, one count each
    for (int c = 0; c < 3; c++) begin
      for (int v = 1; v < 10; v++) begin pre_hi = 4'(v); cyc(3); end
      pre_hi = 4'd0; cyc(3);
      cnt_m++;
    end
    snapshot("R1 prescaler cycle");

    // R7: latch frozen while counter runs
    for (int i = 0; i < 4; i++) pulse(4'b0100);
    expect_held("R7 hold");
    snapshot("R7 after hold");

    // R5 R8: sticky overflow
    ovf_pulse();
    snapshot("R5 R8 ovf set");
    ovf_in = 1'b1; cyc(5);
    expect_held("R8 ovf held");
    ovf_in = 1'b0; cyc(5);
    snapshot("R5 second edge");

    // R4: clear does not touch latch, then clears counter and flag
    clear(1'b0);
    expect_held("R4 latch unaffected");
    snapshot("R4 cleared");

    // R2: decimal carry
    for (int i = 0; i < 99; i++) pulse(4'b0100);
    snapshot("R2 at 099");
    pulse(4'b1000);
    snapshot("R2 carry 100");

    // R3 R6: wrap and internal overflow source
    for (int i = 0; i < 899; i++) pulse(4'b0100);
    snapshot("R6 at 999");
    pulse(4'b0100);
    snapshot("R3 R6 wrap");

    clear(1'b0);
    snapshot("R4 clears internal ovf");

    // R4: overflow edge during clear has no effect
    clear(1'b1);
    snapshot("R4 ovf during clear");

    cyc(2);
    finish_run();
  end
endmodule